// File: doc/BRIEF.md
# Privileged interrupt trap arbiter

This block decides, for a hart that runs in machine, supervisor or user privilege, whether a pending interrupt is to be taken. It also decides whether the trap goes to machine mode or to supervisor mode. The inputs are the current privilege level, the two global interrupt enables, and the 16-bit pending and enable vectors. The block holds the 16-bit delegation mask itself. Delegation sets the route of each interrupt. A non-delegated interrupt belongs to machine mode, whatever its name. It is taken from supervisor or user mode even while the machine global enable is clear. A delegated interrupt is never taken while the hart is in machine mode.

The decision is registered and qualified by an instruction-boundary strobe, so at most one trap is flagged per retired instruction. The block also presents the supervisor views of the pending and enable vectors, masked by the delegation mask. The trap flags and cause feed the trap-entry logic. The views feed the supervisor CSR read path.

Top module: `irq_trap_arbiter`

## Requirements
- R1: While reset is held and after its release, `trap_m` and `trap_s` are 0, `trap_cause` is 0 and `deleg_q` is 0.
- R2: In machine mode, a non-delegated interrupt with its pending and enable bits both 1 raises `trap_m` only when `glb_mie` is 1. An interrupt whose enable bit is 0 never traps.
- R3: In supervisor mode (`priv` = 01) or user mode (00), a non-delegated pending and enabled interrupt raises `trap_m` whatever the value of `glb_mie`. This includes the supervisor timer at bit 5.
- R4: A delegated pending and enabled interrupt raises `trap_s` in user mode always, and in supervisor mode only when `glb_sie` is 1.
- R5: A delegated interrupt never raises `trap_s` while `priv` is 11.
- R6: When both a machine-bound trap and a supervisor-bound trap are eligible, `trap_m` is raised with the machine-bound cause and `trap_s` stays 0.
- R7: Among eligible interrupts with the same target, `trap_cause` (the bit index) follows the priority 11, 3, 7, 9, 1, 5, highest first.
- R8: Only bits 1, 3, 5, 7, 9 and 11 of the vectors can cause a trap. Every other bit has no effect.
- R9: The trap flags are updated only at a clock edge where `insn_boundary` is 1. Otherwise both flags are 0 the next cycle. `trap_cause` changes only when a trap is flagged.
- R10: A write through `deleg_wr` keeps only bits 1, 5 and 9 of `deleg_wdata`. Bits 3, 7, 11 and all nonstandard bits read back as 0 on `deleg_q`.
- R11: `sip_view[i]` equals `irq_pend[i]` and `sie_view[i]` equals `irq_en[i]` when `deleg_q[i]` is 1. Otherwise both read 0.
- R12: The encoding `priv` = 10 behaves as machine mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| glb_mie | input | 1 | Machine global interrupt enable |
| glb_sie | input | 1 | Supervisor global interrupt enable |
| irq_pend | input | 16 | Pending interrupt vector |
| irq_en | input | 16 | Interrupt enable vector |
| deleg_wr | input | 1 | Write strobe for the delegation mask |
| deleg_wdata | input | 16 | Delegation mask write data |
| insn_boundary | input | 1 | Instruction retires this cycle; a trap may be flagged |
| trap_m | output | 1 | Take trap to machine mode (registered pulse) |
| trap_s | output | 1 | Take trap to supervisor mode (registered pulse) |
| trap_cause | output | 4 | Bit index of the interrupt taken |
| deleg_q | output | 16 | Current delegation mask |
| sip_view | output | 16 | Supervisor view of pending bits |
| sie_view | output | 16 | Supervisor view of enable bits |

## Verification
The routing is tried across all privilege codes, including 10. Each code is combined with the global enables on and off and with the delegation bit set and clear for the same interrupt. A change of target or a missing trap then shows which gating term is wrong. Pending vectors with several standard bits removed one at a time show whether each step of the priority chain is right. A vector with only nonstandard bits set shows whether those bits are fully masked. Delegation writes of all ones and all zeros tell the write mask apart from the view masking. Strobe-low cycles that follow a trap show that the flags are qualified and that the cause holds.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int NSRC = 6;

  typedef enum logic [1:0] {
    PRV_U = 2'b00,
    PRV_S = 2'b01,
    PRV_R = 2'b10,
    PRV_M = 2'b11
  } prv_e;

  // standard interrupt bit positions
  localparam int B_SSI = 1;
  localparam int B_MSI = 3;
  localparam int B_STI = 5;
  localparam int B_MTI = 7;
  localparam int B_SEI = 9;
  localparam int B_MEI = 11;

  // rank k (0 = highest) to bit position
  function automatic int rank_bit(input int k);
    case (k)
      0:       rank_bit = B_MEI;
      1:       rank_bit = B_MSI;
      2:       rank_bit = B_MTI;
      3:       rank_bit = B_SEI;
      4:       rank_bit = B_SSI;
      default: rank_bit = B_STI;
    endcase
  endfunction

  function automatic logic [15:0] std_mask();
    logic [15:0] m;
    m = '0;
    for (int k = 0; k < NSRC; k++) m[rank_bit(k)] = 1'b1;
    return m;
  endfunction

  function automatic logic [15:0] dlg_mask();
    logic [15:0] m;
    m = '0;
    m[B_SSI] = 1'b1;
    m[B_STI] = 1'b1;
    m[B_SEI] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_deleg_reg.sv
module irq_deleg_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr) q_nxt = wdata & wmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  AST_DELEG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr) |-> (q == ($past(wdata) & $past(wmask)))); // R10

endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_arb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [1:0]   priv,
  input  logic         glb_mie,
  input  logic         glb_sie,
  input  logic [W-1:0] pend,
  input  logic [W-1:0] en,
  input  logic [W-1:0] deleg,
  input  logic [W-1:0] smask,
  output logic [W-1:0] m_cand,
  output logic [W-1:0] s_cand
);
  logic in_m, in_s, in_u;
  logic m_open, s_open;
  logic [W-1:0] live;

  always_comb begin
    in_u   = (priv == PRV_U);
    in_s   = (priv == PRV_S);
    in_m   = !in_u && !in_s;          // 11 and reserved 10
    m_open = in_m ? glb_mie : 1'b1;
    s_open = in_u | (in_s & glb_sie);
    live   = pend & en & smask;
    m_cand = m_open ? (live & ~deleg) : '0;
    s_cand = s_open ? (live &  deleg) : '0;
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  cand,
  output logic          hit,
  output logic [CW-1:0] cause
);
  logic [NSRC-1:0] rank_hit;

  for (genvar k = 0; k < NSRC; k++) begin : g_rank
    assign rank_hit[k] = cand[rank_bit(k)];
  end

  always_comb begin
    hit   = 1'b0;
    cause = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (rank_hit[k]) begin
        hit   = 1'b1;
        cause = CW'(rank_bit(k));
      end
    end
  end

endmodule

// File: rtl/irq_trap_arbiter.sv
module irq_trap_arbiter
  import irq_arb_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    priv,
  input  logic          glb_mie,
  input  logic          glb_sie,
  input  logic [W-1:0]  irq_pend,
  input  logic [W-1:0]  irq_en,
  input  logic          deleg_wr,
  input  logic [W-1:0]  deleg_wdata,
  input  logic          insn_boundary,
  output logic          trap_m,
  output logic          trap_s,
  output logic [CW-1:0] trap_cause,
  output logic [W-1:0]  deleg_q,
  output logic [W-1:0]  sip_view,
  output logic [W-1:0]  sie_view
);
  localparam logic [W-1:0] SMASK = W'(std_mask());
  localparam logic [W-1:0] DMASK = W'(dlg_mask());

  logic [W-1:0]  m_cand, s_cand;
  logic          m_hit, s_hit;
  logic [CW-1:0] m_cause, s_cause;
  logic          trap_m_nxt, trap_s_nxt;
  logic [CW-1:0] cause_nxt;
  logic          cause_en;

  irq_deleg_reg #(.W(W)) u_deleg (
    .clk(clk), .rst_n(rst_n), .wr(deleg_wr), .wdata(deleg_wdata),
    .wmask(DMASK), .q(deleg_q)
  );

  assign sip_view = irq_pend & deleg_q;
  assign sie_view = irq_en   & deleg_q;

  irq_route #(.W(W)) u_route (
    .priv(priv), .glb_mie(glb_mie), .glb_sie(glb_sie),
    .pend(irq_pend), .en(irq_en), .deleg(deleg_q), .smask(SMASK),
    .m_cand(m_cand), .s_cand(s_cand)
  );

  irq_pick #(.W(W), .CW(CW)) u_pick_m (.cand(m_cand), .hit(m_hit), .cause(m_cause));
  irq_pick #(.W(W), .CW(CW)) u_pick_s (.cand(s_cand), .hit(s_hit), .cause(s_cause));

  always_comb begin
    trap_m_nxt = insn_boundary & m_hit;
    trap_s_nxt = insn_boundary & s_hit & ~m_hit;
    cause_en   = trap_m_nxt | trap_s_nxt;
    cause_nxt  = m_hit ? m_cause : s_cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_m <= 1'b0;
      trap_s <= 1'b0;
    end else begin
      trap_m <= trap_m_nxt;
      trap_s <= trap_s_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trap_cause <= '0;
    else if (cause_en) trap_cause <= cause_nxt;
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_m && trap_s)); // R6
  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_m || trap_s) |-> $past(insn_boundary)); // R9
  AST_NO_S_FROM_M: assert property (@(posedge clk) disable iff (!rst_n)
    trap_s |-> ($past(priv) == PRV_U || $past(priv) == PRV_S)); // R5
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_m || trap_s) |-> $stable(trap_cause)); // R9
  AST_CAUSE_STD: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_m || trap_s) |-> SMASK[trap_cause]); // R8
  AST_DELEG_MONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (deleg_q[B_MSI] | deleg_q[B_MTI] | deleg_q[B_MEI]) == 1'b0); // R10

endmodule

// File: tb/irq_trap_arbiter_bench.sv
module irq_trap_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  priv;
  logic        glb_mie, glb_sie;
  logic [15:0] irq_pend, irq_en;
  logic        deleg_wr;
  logic [15:0] deleg_wdata;
  logic        insn_boundary;
  logic        trap_m, trap_s;
  logic [3:0]  trap_cause;
  logic [15:0] deleg_q, sip_view, sie_view;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_trap_arbiter u_irq_trap_arbiter (
    .clk(clk), .rst_n(rst_n), .priv(priv), .glb_mie(glb_mie), .glb_sie(glb_sie),
    .irq_pend(irq_pend), .irq_en(irq_en), .deleg_wr(deleg_wr),
    .deleg_wdata(deleg_wdata), .insn_boundary(insn_boundary),
    .trap_m(trap_m), .trap_s(trap_s), .trap_cause(trap_cause),
    .deleg_q(deleg_q), .sip_view(sip_view), .sie_view(sie_view)
  );

  // {priv, mie, sie, pend, en, deleg, exp_m, exp_s, exp_cause}
  localparam logic [57:0] VECS [0:NV-1] = '{
    {2'd3,1'b1,1'b0,16'h0080,16'hFFFF,16'h0000,1'b1,1'b0,4'd7},  // R2
    {2'd3,1'b0,1'b0,16'h0080,16'hFFFF,16'h0000,1'b0,1'b0,4'd0},  // R2
    {2'd1,1'b0,1'b0,16'h0020,16'h0020,16'h0000,1'b1,1'b0,4'd5},  // R3
    {2'd0,1'b0,1'b0,16'h0200,16'hFFFF,16'h0000,1'b1,1'b0,4'd9},  // R3
    {2'd1,1'b0,1'b1,16'h0020,16'hFFFF,16'h0020,1'b0,1'b1,4'd5},  // R4
    {2'd1,1'b1,1'b0,16'h0020,16'hFFFF,16'h0020,1'b0,1'b0,4'd0},  // R4
    {2'd0,1'b0,1'b0,16'h0002,16'hFFFF,16'h0002,1'b0,1'b1,4'd1},  // R4
    {2'd3,1'b1,1'b1,16'h0020,16'hFFFF,16'h0020,1'b0,1'b0,4'd0},  // R5
    {2'd1,1'b0,1'b1,16'h0022,16'hFFFF,16'h0020,1'b1,1'b0,4'd1},  // R6
    {2'd3,1'b1,1'b0,16'h0AAA,16'hFFFF,16'h0000,1'b1,1'b0,4'd11}, // R7
    {2'd3,1'b1,1'b0,16'h0288,16'hFFFF,16'h0000,1'b1,1'b0,4'd3},  // R7
    {2'd3,1'b1,1'b0,16'h0282,16'hFFFF,16'h0000,1'b1,1'b0,4'd7},  // R7
    {2'd3,1'b1,1'b0,16'h0222,16'hFFFF,16'h0000,1'b1,1'b0,4'd9},  // R7
    {2'd3,1'b1,1'b0,16'h0022,16'hFFFF,16'h0000,1'b1,1'b0,4'd1},  // R7
    {2'd1,1'b0,1'b1,16'h0222,16'hFFFF,16'h0222,1'b0,1'b1,4'd9},  // R7
    {2'd3,1'b1,1'b1,16'hF555,16'hFFFF,16'h0000,1'b0,1'b0,4'd0},  // R8
    {2'd2,1'b0,1'b0,16'h0080,16'hFFFF,16'h0000,1'b0,1'b0,4'd0},  // R12
    {2'd2,1'b1,1'b1,16'h0020,16'hFFFF,16'h0020,1'b0,1'b0,4'd0},  // R12
    {2'd3,1'b1,1'b0,16'h0080,16'hFF7F,16'h0000,1'b0,1'b0,4'd0}   // R2
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_deleg(input logic [15:0] d);
    @(negedge clk);
    deleg_wr = 1'b1; deleg_wdata = d;
    @(negedge clk);
    deleg_wr = 1'b0;
  endtask

  task automatic step(input logic [1:0] p, input logic mi, input logic si,
                      input logic [15:0] pe, input logic [15:0] en, input logic bnd);
    @(negedge clk);
    priv = p; glb_mie = mi; glb_sie = si; irq_pend = pe; irq_en = en;
    insn_boundary = bnd;
    @(negedge clk);
    insn_boundary = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; priv = 2'd3; glb_mie = 1'b0; glb_sie = 1'b0;
    irq_pend = '0; irq_en = '0; deleg_wr = 1'b0; deleg_wdata = '0;
    insn_boundary = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "trap_m in reset", 32'(trap_m), 0);
    check("R1", "trap_s in reset", 32'(trap_s), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "trap_cause", 32'(trap_cause), 0);
    check("R1", "deleg_q", 32'(deleg_q), 0);

    for (int v = 0; v < NV; v++) begin
      logic [57:0] e;
      e = VECS[v];
      wr_deleg(e[21:6]);
      step(e[57:56], e[55], e[54], e[53:38], e[37:22], 1'b1);
      check($sformatf("R%0d-vec%0d", 0, v), "trap_m", 32'(trap_m), 32'(e[5]));
      check($sformatf("vec%0d", v), "trap_s", 32'(trap_s), 32'(e[4]));
      if (e[5] || e[4])
        check($sformatf("vec%0d", v), "trap_cause", 32'(trap_cause), 32'(e[3:0]));
    end

    // R9: trap then strobe low, cause holds
    wr_deleg(16'h0000);
    step(2'd3, 1'b1, 1'b0, 16'h0800, 16'hFFFF, 1'b1);
    check("R9", "trap_m at boundary", 32'(trap_m), 1);
    check("R9", "cause 11", 32'(trap_cause), 11);
    step(2'd3, 1'b1, 1'b0, 16'h0008, 16'hFFFF, 1'b0);
    check("R9", "trap_m without boundary", 32'(trap_m), 0);
    check("R9", "trap_s without boundary", 32'(trap_s), 0);
    check("R9", "cause held", 32'(trap_cause), 11);

    // R10: write mask on delegation
    wr_deleg(16'hFFFF);
    check("R10", "deleg_q after all-ones", 32'(deleg_q), 32'h0222);
    // R11: supervisor views
    irq_pend = 16'hFFFF; irq_en = 16'h00F0;
    @(negedge clk);
    check("R11", "sip_view", 32'(sip_view), 32'h0222);
    check("R11", "sie_view", 32'(sie_view), 32'h0020);
    wr_deleg(16'h0000);
    check("R11", "sip_view no deleg", 32'(sip_view), 0);
    check("R11", "sie_view no deleg", 32'(sie_view), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule